// File: doc/BRIEF.md
# CAM Host Cycle Controller

This block sits between a 16-bit host bus and a content-addressable memory array. It does not hold the array. It frames host cycles, decodes the command words the host writes, and keeps the pointers that the array side uses. Each bus cycle is bracketed by an active-low cycle enable, which is synchronous to `clk`. When the enable goes low, the controller captures the write-select and command-select inputs, and these two inputs fix the cycle as one of four types. When the enable goes high again, the cycle completes. At that point the controller acts on the word on `dq_in` and steps its segment counters. Read data is driven through a separate output with an output-enable. That enable drops in the same clock cycle in which the cycle enable returns high.

The destination segment counter picks the 16-bit slice that a data write loads. The source segment counter picks the slice that a data read returns. Each counter steps inside a range that the host programs. The address register is loaded by an absolute-address operand, and it can step up or down after each memory operation that uses it. Some instructions need a second command write that carries an operand. The controller remembers which instruction is waiting for that operand.

The host bus is a plain strobed bus and has no back-pressure: every cycle completes when the enable rises. The controller never stalls the host.

Top module: `cam_cyc_ctrl`

## Requirements
- R1: The cycle type is taken from `wr_n` (0 = write, 1 = read) and `cmd_n` (0 = command, 1 = data) on the clock edge where `cyc_en_n` is first seen low. Later changes to either input during the same cycle have no effect.
- R2: `dq_oe` is high only during a read cycle, from one clock after the enable falls until the enable is high again. It is low as soon as `cyc_en_n` is high, with no clock edge needed.
- R3: A data write raises `dwr_stb` for exactly one clock, on the clock after the enable rises. The strobe carries the `dq_in` value present at the rise and the destination segment that applied during the cycle. The destination counter then steps.
- R4: During a data read, `dq_out` equals `rd_data_i`, and `src_seg` stays constant through the cycle. The source counter steps when the cycle ends.
- R5: A segment counter that steps from the upper bound of its range goes to the lower bound. Otherwise it adds one. After reset both ranges are 0 to 3 and both counters are 0.
- R6: A command word with bits 15:12 = 0001 loads the ranges and sets each counter to its new lower bound. The fields are: destination low in bits 7:6, destination high in bits 5:4, source low in bits 3:2, source high in bits 1:0.
- R7: A command word with bits 15:12 = 0010 sets the address step mode from bits 1:0. The codes are 01 = increment, 10 = decrement, and 00 or 11 = hold. Stepping wraps modulo 2^AW.
- R8: A validity command has the form 0000 f100 00ddd vvv, with f in bit 11. When f = 0, `vbc_stb` pulses with `vbc_dst` = ddd, `vbc_val` = vvv and `vbc_addr` = the current address. The address then steps by the mode.
- R9: When f = 1 in a validity command, nothing is emitted at first. The next command write supplies the address in its low AW bits. That address is loaded into the address register without stepping, and `vbc_stb` pulses with it.
- R10: A command read returns the address register, zero-extended. In the single cycle right after a command word with bits 15:12 = 0101, a command read returns `nf_addr_i` instead.
- R11: A command word with bits 15:12 = 0011 takes the next command write as a control word. If bit 15 of the control word is 0, the address, the step mode, both ranges, both counters and the next-free selection return to their reset values. If bit 15 is 1, nothing changes.
- R12: A pending operand is abandoned by any cycle that is not a command write. A later command write is then decoded as an instruction.
- R13: Command words with any other opcode in bits 15:12 change no state and emit no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en_n | input | 1 | Active-low cycle enable |
| wr_n | input | 1 | Write-select, low for write |
| cmd_n | input | 1 | Command-select, low for command |
| dq_in | input | 16 | Host write data |
| dq_out | output | 16 | Host read data |
| dq_oe | output | 1 | Read data output-enable |
| rd_data_i | input | 16 | Segment data from the array for `src_seg` |
| nf_addr_i | input | 16 | Next-free value from the array |
| src_seg | output | 2 | Source segment index |
| dst_seg | output | 2 | Destination segment index |
| dwr_stb | output | 1 | Data write strobe |
| dwr_seg | output | 2 | Segment for the data write |
| dwr_data | output | 16 | Data for the data write |
| vbc_stb | output | 1 | Validity command strobe |
| vbc_dst | output | 3 | Validity destination code |
| vbc_val | output | 3 | Validity setting code |
| vbc_addr | output | AW | Address for the validity command |

## Verification
The assertions assume that `cyc_en_n` stays low for at least one clock and high for at least one clock between cycles. They also assume that the host never programs a range whose lower bound exceeds its upper bound. The stimulus drives every cycle through one task that holds the enable low for one clock and then high for at least one clock. Range words are built from sorted bound pairs. Every other field of a command word is random, and the opcode mix is weighted so that pending operands, abandoned operands, reset and non-reset control words, and unknown opcodes all occur.

// File: rtl/cam_cyc_pkg.sv
package cam_cyc_pkg;
  localparam int DW    = 16;
  localparam int SEG_W = 2;

  // {wr_n, cmd_n} captured at the start of a cycle
  typedef enum logic [1:0] {
    CYC_CMD_WR  = 2'b00,
    CYC_DATA_WR = 2'b01,
    CYC_CMD_RD  = 2'b10,
    CYC_DATA_RD = 2'b11
  } cyc_kind_t;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_VBC  = 2'd1,
    PEND_CTRL = 2'd2
  } pend_t;

  localparam logic [3:0] OP_VBC   = 4'h0;
  localparam logic [3:0] OP_RANGE = 4'h1;
  localparam logic [3:0] OP_MODE  = 4'h2;
  localparam logic [3:0] OP_CTRL  = 4'h3;
  localparam logic [3:0] OP_NFSEL = 4'h5;
endpackage

// File: rtl/cam_cyc_frame.sv
module cam_cyc_frame
  import cam_cyc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cyc_en_n,
  input  logic      wr_n,
  input  logic      cmd_n,
  output cyc_kind_t kind,
  output logic      in_cyc,
  output logic      cyc_end
);
  logic en_q;
  logic en_fall;

  assign en_fall = en_q & ~cyc_en_n;
  assign cyc_end = ~en_q & cyc_en_n & in_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      in_cyc <= 1'b0;
      kind   <= CYC_DATA_RD;
    end else begin
      en_q <= cyc_en_n;
      if (en_fall) begin
        kind   <= cyc_kind_t'({wr_n, cmd_n});
        in_cyc <= 1'b1;
      end else if (cyc_en_n) begin
        in_cyc <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cam_seg_ctr.sv
module cam_seg_ctr #(
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] lo_in,
  input  logic [SW-1:0] hi_in,
  input  logic          step,
  output logic [SW-1:0] cnt,
  output logic [SW-1:0] lo,
  output logic [SW-1:0] hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lo  <= '0;
      hi  <= '1;
    end else if (load) begin
      cnt <= lo_in;
      lo  <= lo_in;
      hi  <= hi_in;
    end else if (step) begin
      cnt <= (cnt == hi) ? lo : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cam_addr_unit.sv
module cam_addr_unit #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          mode_we,
  input  logic [1:0]    mode_in,
  output logic [AW-1:0] addr
);
  logic [1:0] mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      mode <= 2'b00;
    end else if (clr) begin
      addr <= '0;
      mode <= 2'b00;
    end else begin
      if (mode_we) mode <= mode_in;
      if (load) begin
        addr <= load_val;
      end else if (step) begin
        unique case (mode)
          2'b01:   addr <= addr + 1'b1;
          2'b10:   addr <= addr - 1'b1;
          default: addr <= addr;
        endcase
      end
    end
  end
endmodule

// File: rtl/cam_cyc_ctrl.sv
module cam_cyc_ctrl
  import cam_cyc_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_en_n,
  input  logic          wr_n,
  input  logic          cmd_n,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] rd_data_i,
  input  logic [DW-1:0] nf_addr_i,
  output logic [SEG_W-1:0] src_seg,
  output logic [SEG_W-1:0] dst_seg,
  output logic          dwr_stb,
  output logic [SEG_W-1:0] dwr_seg,
  output logic [DW-1:0] dwr_data,
  output logic          vbc_stb,
  output logic [2:0]    vbc_dst,
  output logic [2:0]    vbc_val,
  output logic [AW-1:0] vbc_addr
);
  localparam int NCTR = 2;  // index 0: destination, 1: source

  cyc_kind_t kind;
  logic      in_cyc, cyc_end;
  pend_t     pend;
  logic      nf_sel;
  logic [2:0] held_dst, held_val;
  logic [AW-1:0] addr_q;

  cam_cyc_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cyc_en_n(cyc_en_n), .wr_n(wr_n), .cmd_n(cmd_n),
    .kind(kind), .in_cyc(in_cyc), .cyc_end(cyc_end)
  );

  // ---- instruction decode, only meaningful at cycle end ----
  logic [3:0] op;
  logic end_cw, end_dw, end_dr, instr_cw, is_vbc;
  logic ctrl_clr, addr_load, addr_step, mode_we, rng_we;

  assign op       = dq_in[15:12];
  assign end_cw   = cyc_end && (kind == CYC_CMD_WR);
  assign end_dw   = cyc_end && (kind == CYC_DATA_WR);
  assign end_dr   = cyc_end && (kind == CYC_DATA_RD);
  assign instr_cw = end_cw && (pend == PEND_NONE);
  assign is_vbc   = (op == OP_VBC) && (dq_in[10:8] == 3'b100) && (dq_in[7:6] == 2'b00);

  assign ctrl_clr  = end_cw && (pend == PEND_CTRL) && !dq_in[15];
  assign addr_load = end_cw && (pend == PEND_VBC);
  assign addr_step = instr_cw && is_vbc && !dq_in[11];
  assign mode_we   = instr_cw && (op == OP_MODE);
  assign rng_we    = instr_cw && (op == OP_RANGE);

  cam_addr_unit #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(ctrl_clr), .load(addr_load),
    .load_val(dq_in[AW-1:0]), .step(addr_step), .mode_we(mode_we),
    .mode_in(dq_in[1:0]), .addr(addr_q)
  );

  // ---- segment counters ----
  logic [SEG_W-1:0] ctr_lo_in [NCTR];
  logic [SEG_W-1:0] ctr_hi_in [NCTR];
  logic [SEG_W-1:0] ctr_cnt   [NCTR];
  logic [SEG_W-1:0] ctr_lo    [NCTR];
  logic [SEG_W-1:0] ctr_hi    [NCTR];
  logic             ctr_step  [NCTR];

  assign ctr_step[0] = end_dw;
  assign ctr_step[1] = end_dr;

  genvar gi;
  generate
    for (gi = 0; gi < NCTR; gi++) begin : g_seg
      localparam int FB = 6 - 4 * gi;  // low-bound field position in range word
      assign ctr_lo_in[gi] = ctrl_clr ? '0 : dq_in[FB+1:FB];
      assign ctr_hi_in[gi] = ctrl_clr ? '1 : dq_in[FB-1:FB-2];
      cam_seg_ctr #(.SW(SEG_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(rng_we || ctrl_clr),
        .lo_in(ctr_lo_in[gi]), .hi_in(ctr_hi_in[gi]), .step(ctr_step[gi]),
        .cnt(ctr_cnt[gi]), .lo(ctr_lo[gi]), .hi(ctr_hi[gi])
      );
    end
  endgenerate

  logic [SEG_W-1:0] dst_lo, dst_hi, src_lo, src_hi;
  assign dst_seg = ctr_cnt[0];
  assign src_seg = ctr_cnt[1];
  assign dst_lo  = ctr_lo[0];
  assign dst_hi  = ctr_hi[0];
  assign src_lo  = ctr_lo[1];
  assign src_hi  = ctr_hi[1];

  // ---- sequencing state and output strobes ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= PEND_NONE;
      nf_sel   <= 1'b0;
      held_dst <= '0;
      held_val <= '0;
      dwr_stb  <= 1'b0;
      dwr_seg  <= '0;
      dwr_data <= '0;
      vbc_stb  <= 1'b0;
      vbc_dst  <= '0;
      vbc_val  <= '0;
      vbc_addr <= '0;
    end else begin
      dwr_stb <= 1'b0;
      vbc_stb <= 1'b0;
      if (cyc_end) begin
        nf_sel <= instr_cw && (op == OP_NFSEL);
        pend   <= PEND_NONE;
        if (end_dw) begin
          dwr_stb  <= 1'b1;
          dwr_seg  <= dst_seg;
          dwr_data <= dq_in;
        end
        if (addr_load) begin
          vbc_stb  <= 1'b1;
          vbc_dst  <= held_dst;
          vbc_val  <= held_val;
          vbc_addr <= dq_in[AW-1:0];
        end
        if (instr_cw && is_vbc) begin
          if (dq_in[11]) begin
            pend     <= PEND_VBC;
            held_dst <= dq_in[5:3];
            held_val <= dq_in[2:0];
          end else begin
            vbc_stb  <= 1'b1;
            vbc_dst  <= dq_in[5:3];
            vbc_val  <= dq_in[2:0];
            vbc_addr <= addr_q;
          end
        end
        if (instr_cw && (op == OP_CTRL)) pend <= PEND_CTRL;
      end
    end
  end

  // ---- read path ----
  assign dq_oe  = in_cyc && kind[1] && !cyc_en_n;
  assign dq_out = (kind == CYC_DATA_RD) ? rd_data_i :
                  (nf_sel ? nf_addr_i : {{(DW-AW){1'b0}}, addr_q});
endmodule

// File: rtl/cam_cyc_chk.sv
module cam_cyc_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_en_n,
  input logic          dq_oe,
  input logic          dwr_stb,
  input logic          vbc_stb,
  input logic          cyc_end,
  input logic [1:0]    src_seg,
  input logic [1:0]    dst_seg,
  input logic [1:0]    dst_lo,
  input logic [1:0]    dst_hi,
  input logic [AW-1:0] addr_q
);
  p_oe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en_n |-> !dq_oe);

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dwr_stb |-> !vbc_stb);

  p_dwr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dwr_stb |=> !dwr_stb);

  p_src_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(src_seg));

  p_dst_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_lo <= dst_hi) |-> (dst_seg >= dst_lo && dst_seg <= dst_hi));

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(addr_q));
endmodule

bind cam_cyc_ctrl cam_cyc_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_en_n(cyc_en_n), .dq_oe(dq_oe),
  .dwr_stb(dwr_stb), .vbc_stb(vbc_stb), .cyc_end(cyc_end),
  .src_seg(src_seg), .dst_seg(dst_seg), .dst_lo(dst_lo), .dst_hi(dst_hi),
  .addr_q(addr_q)
);

// File: tb/tb_cam_cyc_ctrl.sv
`timescale 1ns/1ps
module tb_cam_cyc_ctrl;
  localparam int AW = 11;
  localparam logic [15:0] NF_VAL = 16'h7C2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_en_n = 1'b1, wr_n = 1'b1, cmd_n = 1'b1;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, rd_data_i;
  logic dq_oe, dwr_stb, vbc_stb;
  logic [1:0] src_seg, dst_seg, dwr_seg;
  logic [15:0] dwr_data;
  logic [2:0] vbc_dst, vbc_val;
  logic [AW-1:0] vbc_addr;

  always #4 clk = ~clk;
  assign rd_data_i = 16'hA500 | {14'b0, src_seg};

  cam_cyc_ctrl #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cyc_en_n(cyc_en_n), .wr_n(wr_n), .cmd_n(cmd_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .rd_data_i(rd_data_i),
    .nf_addr_i(NF_VAL), .src_seg(src_seg), .dst_seg(dst_seg),
    .dwr_stb(dwr_stb), .dwr_seg(dwr_seg), .dwr_data(dwr_data),
    .vbc_stb(vbc_stb), .vbc_dst(vbc_dst), .vbc_val(vbc_val), .vbc_addr(vbc_addr)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [AW-1:0] m_addr;
  logic [1:0] m_mode, m_dlo, m_dhi, m_slo, m_shi, m_dcnt, m_scnt;
  logic m_nf;
  int   m_pend;  // 0 none, 1 validity, 2 control
  logic [2:0] m_hdst, m_hval;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] wrap(input logic [1:0] c, input logic [1:0] lo, input logic [1:0] hi);
    return (c == hi) ? lo : c + 2'd1;
  endfunction

  function automatic logic [AW-1:0] astep(input logic [AW-1:0] a, input logic [1:0] md);
    return (md == 2'b01) ? a + 1'b1 : (md == 2'b10) ? a - 1'b1 : a;
  endfunction

  task automatic model_reset();
    m_addr = '0; m_mode = 0; m_dlo = 0; m_dhi = 3; m_slo = 0; m_shi = 3;
    m_dcnt = 0; m_scnt = 0; m_nf = 0; m_pend = 0; m_hdst = 0; m_hval = 0;
  endtask

  // one host cycle: w = wr_n, c = cmd_n
  task automatic bus(input logic w, input logic c, input logic [15:0] d);
    logic [15:0] rd;
    logic oe, e_dwr, e_vbc;
    logic [2:0] e_vdst, e_vval;
    logic [AW-1:0] e_vaddr;
    logic [3:0] op;
    @(negedge clk);
    cyc_en_n = 1'b0; wr_n = w; cmd_n = c; dq_in = d;
    @(negedge clk);
    oe = dq_oe; rd = dq_out;
    chk(oe == w, "R2 oe in cycle", oe, w);
    chk(src_seg == m_scnt, "R4 src seg", src_seg, m_scnt);
    chk(dst_seg == m_dcnt, "R5 dst seg", dst_seg, m_dcnt);
    wr_n = ~w; cmd_n = ~c;  // R1: late changes must not alter the cycle
    cyc_en_n = 1'b1;
    #1;
    chk(!dq_oe, "R2 oe off at rise", dq_oe, 0);
    @(negedge clk);
    e_dwr = 0; e_vbc = 0; e_vdst = 0; e_vval = 0; e_vaddr = 0;
    op = d[15:12];
    if (w && c) begin  // data read
      chk(rd == (16'hA500 | m_scnt), "R1 R4 data read", rd, 16'hA500 | m_scnt);
      m_scnt = wrap(m_scnt, m_slo, m_shi); m_pend = 0; m_nf = 0;
    end else if (w && !c) begin  // command read
      logic [15:0] ex;
      ex = m_nf ? NF_VAL : {5'b0, m_addr};
      chk(rd == ex, "R10 command read", rd, ex);
      m_pend = 0; m_nf = 0;
    end else if (!w && c) begin  // data write
      e_dwr = 1;
      chk(dwr_seg == m_dcnt && dwr_data == d, "R1 R3 data write seg/data",
          {dwr_seg, dwr_data}, {m_dcnt, d});
      m_dcnt = wrap(m_dcnt, m_dlo, m_dhi); m_pend = 0; m_nf = 0;
    end else begin  // command write
      m_nf = 0;
      if (m_pend == 1) begin
        e_vbc = 1; e_vdst = m_hdst; e_vval = m_hval; e_vaddr = d[AW-1:0];
        m_addr = d[AW-1:0]; m_pend = 0;
      end else if (m_pend == 2) begin
        if (!d[15]) model_reset();
        m_pend = 0;
      end else if (op == 4'h0 && d[10:8] == 3'b100 && d[7:6] == 2'b00) begin
        if (d[11]) begin
          m_pend = 1; m_hdst = d[5:3]; m_hval = d[2:0];
        end else begin
          e_vbc = 1; e_vdst = d[5:3]; e_vval = d[2:0]; e_vaddr = m_addr;
          m_addr = astep(m_addr, m_mode);
        end
      end else if (op == 4'h1) begin
        m_dlo = d[7:6]; m_dhi = d[5:4]; m_slo = d[3:2]; m_shi = d[1:0];
        m_dcnt = m_dlo; m_scnt = m_slo;
      end else if (op == 4'h2) m_mode = d[1:0];
      else if (op == 4'h3) m_pend = 2;
      else if (op == 4'h5) m_nf = 1;
      // other opcodes: R13, no effect
    end
    chk(dwr_stb == e_dwr, "R3 dwr strobe", dwr_stb, e_dwr);
    chk(vbc_stb == e_vbc, "R8 R9 R12 R13 vbc strobe", vbc_stb, e_vbc);
    if (e_vbc)
      chk(vbc_dst == e_vdst && vbc_val == e_vval && vbc_addr == e_vaddr,
          "R8 R9 vbc fields", {vbc_dst, vbc_val, vbc_addr}, {e_vdst, e_vval, e_vaddr});
  endtask

  function automatic logic [15:0] rnd_cmd();
    logic [1:0] a, b, x, y;
    case ($urandom % 8)
      0, 1: return {4'h0, 1'($urandom), 5'b10000, 6'($urandom)};
      2: begin
        a = 2'($urandom); b = 2'($urandom); x = 2'($urandom); y = 2'($urandom);
        if (a > b) begin logic [1:0] t; t = a; a = b; b = t; end
        if (x > y) begin logic [1:0] t; t = x; x = y; y = t; end
        return {4'h1, 4'h0, a, b, x, y};
      end
      3: return {4'h2, 12'($urandom)};
      4: return {4'h3, 12'($urandom)};
      5: return {4'h5, 12'($urandom)};
      6: return {4'(6 + $urandom % 10), 12'($urandom)};
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dq_oe && !dwr_stb && !vbc_stb, "R2 reset idle outputs", {dq_oe, dwr_stb, vbc_stb}, 0);
    chk(src_seg == 0 && dst_seg == 0, "R5 reset counters", {src_seg, dst_seg}, 0);
    bus(1, 0, 16'h0);                          // R10 address 0 after reset
    bus(0, 0, 16'h1060);                       // R6 dst 1..2, src 0..0
    bus(0, 1, 16'h1111); bus(0, 1, 16'h2222); bus(0, 1, 16'h3333);  // R5 wrap 1,2,1
    bus(1, 1, 16'h0); bus(1, 1, 16'h0);        // R4 src range of one
    bus(0, 0, 16'h2001);                       // R7 increment
    bus(0, 0, 16'h042D); bus(0, 0, 16'h0415);  // R8 f=0 twice
    bus(0, 0, 16'h0C3A); bus(0, 0, 16'h05AB);  // R9 f=1 + operand
    bus(0, 0, 16'h2002); bus(0, 0, 16'h0400);  // R7 decrement
    bus(1, 0, 16'h0);
    bus(0, 0, 16'h5000); bus(1, 0, 16'h0); bus(1, 0, 16'h0);  // R10 one-shot
    bus(0, 0, 16'h5000); bus(0, 1, 16'hBEEF); bus(1, 0, 16'h0);  // R10 expired
    bus(0, 0, 16'h3000); bus(0, 0, 16'h8000); bus(1, 0, 16'h0);  // R11 no reset
    bus(0, 0, 16'h3000); bus(0, 0, 16'h0000); bus(1, 0, 16'h0);  // R11 reset
    bus(0, 0, 16'h0C01); bus(1, 1, 16'h0); bus(0, 0, 16'h0409); // R12 abandon
    bus(0, 0, 16'h7FFF); bus(0, 0, 16'hF0F0); bus(1, 0, 16'h0);  // R13 unknown
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom % 4;
      if (k == 0) bus(0, 0, (m_pend != 0) ? 16'($urandom) : rnd_cmd());
      else bus(k[1], ~k[0] | k[1] & k[0] ? 1'b1 : 1'b0, 16'($urandom));
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1_200_000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule